// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the timing engine of a direct-memory-access controller. Once a channel raises its request, the sequencer asks the CPU for the system bus and waits for the CPU to grant it. It then runs each word through a fixed schedule of working states, one clock per state. The first working state latches the address. The other three carry the read or write command. Slow targets can stretch the command by holding the ready line low.

Two kinds of transfer are supported. In a fly-by transfer the device and memory exchange the word directly; one memory address is issued per word, and a direction bit picks the command. In a memory-to-memory copy each word takes two passes of four working states. The first pass reads from the source address into an internal temporary register. The second pass writes that register to the destination address.

Burst mode keeps the bus for the whole block. Single mode hands the bus back after every word and asks for it again. The start addresses and the word count are taken from ports when a block begins, and the controller may be reprogrammed only while no block is in progress.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset and between blocks, `holdReq`, `addrStrobe`, `rdStrobe`, `wrStrobe` and `eot` are low. `progEnable` is high only while the sequencer is idle with no block in progress, and is never high while `holdReq` is high.
- R2: When `chanReq` is sampled high while idle, `holdReq` rises on the next cycle. No working state starts until `holdAck` is sampled high, and the sequencer waits indefinitely for it.
- R3: After the grant, each pass consists of working states of one clock each. The first asserts `addrStrobe` with the pass address on `busAddr`. The next three assert one command strobe.
- R4: A low `ready` sampled in the third working state inserts wait states that hold the command strobe. The sequencer leaves the wait state in the cycle after `ready` is sampled high, so w wait cycles give 4+w cycles per pass.
- R5: With `memToMem`=1, every word takes a read pass (`rdStrobe`, source address) and then a write pass (`wrStrobe`, destination address). At the end of the read pass, `memRdata` is captured into `tmpData`, which holds it through the write pass.
- R6: A block moves `wordCount`+1 words. The source address increases by one after every word, and the destination address also increases by one after every memory-to-memory word.
- R7: With `burstMode`=1, `holdReq` stays high from the request through the last word and falls exactly once per block.
- R8: With `burstMode`=0, `holdReq` falls after every word and is raised again while `chanReq` stays high. Address and count ports are not reloaded in the middle of a block.
- R9: `eot` is a one-cycle pulse in the final working state of the last word. On the next cycle `holdReq` is low and `progEnable` is high.
- R10: In a fly-by transfer, `dirWrite`=1 selects `wrStrobe` and `dirWrite`=0 selects `rdStrobe`. At most one of `addrStrobe`, `rdStrobe` and `wrStrobe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanReq | input | 1 | Channel service request |
| holdAck | input | 1 | Bus grant from the CPU |
| ready | input | 1 | Target ready; low stretches the command |
| burstMode | input | 1 | 1 = keep bus for the whole block, 0 = release after each word |
| memToMem | input | 1 | 1 = memory-to-memory copy |
| dirWrite | input | 1 | Fly-by direction: 1 = write memory, 0 = read memory |
| srcAddr | input | AW | Start (source) address, loaded at block start |
| dstAddr | input | AW | Destination address for copies, loaded at block start |
| wordCount | input | CW | Words in block minus one |
| memRdata | input | DW | Memory read data |
| holdReq | output | 1 | Bus request to the CPU |
| addrStrobe | output | 1 | Address latch strobe (first working state) |
| rdStrobe | output | 1 | Memory read command |
| wrStrobe | output | 1 | Memory write command |
| busAddr | output | AW | Current transfer address |
| tmpData | output | DW | Temporary copy register, write data for copies |
| eot | output | 1 | End of transfer pulse |
| progEnable | output | 1 | Safe to program: idle with no block in progress |

## Verification
Assertions check the per-cycle rules on every cycle. These are: strobes are mutually exclusive, no cycle starts without a grant, the address strobe is followed by a command, wait states persist while ready is low, the temporary register changes only on capture, `eot` is followed by bus release, and programming is never allowed while holding the bus.

The bench's scenarios cover what only a whole block can show. These are the cycle count per pass with wait states, the number of bus releases in burst versus single mode, the address sequence and increments, the correct copy of the captured read data, and the fact that port changes in the middle of a block are ignored.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_W1,
    ST_W2,
    ST_W3,
    ST_WAIT,
    ST_W4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // take start addresses and count from ports
    logic wordDone;  // last pass of a word finished: step addresses, count
    logic capture;   // end of read pass of a copy: grab read data
    logic useDst;    // drive destination address on the bus
  } dpCtrl_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chanReq,
  input  logic    holdAck,
  input  logic    ready,
  input  logic    burstMode,
  input  logic    memToMem,
  input  logic    dirWrite,
  input  logic    lastWord,
  output logic    holdReq,
  output logic    addrStrobe,
  output logic    rdStrobe,
  output logic    wrStrobe,
  output logic    eot,
  output logic    progEnable,
  output dpCtrl_t dpCtl
);

  seqState_t state, stateNext;
  logic writePass, writePassNext;
  logic midBlock, midBlockNext;
  logic cmdActive;
  logic passEnd;

  assign passEnd = (state == ST_W4);

  always_comb begin
    stateNext     = state;
    writePassNext = writePass;
    midBlockNext  = midBlock;
    unique case (state)
      ST_IDLE: begin
        if (chanReq) begin
          stateNext    = ST_REQ;
          midBlockNext = 1'b1;
        end
      end
      ST_REQ:  if (holdAck) stateNext = ST_W1;
      ST_W1:   stateNext = ST_W2;
      ST_W2:   stateNext = ST_W3;
      ST_W3:   stateNext = ready ? ST_W4 : ST_WAIT;
      ST_WAIT: stateNext = ready ? ST_W4 : ST_WAIT;
      ST_W4: begin
        if (memToMem && !writePass) begin
          stateNext     = ST_W1;
          writePassNext = 1'b1;
        end else begin
          writePassNext = 1'b0;
          if (lastWord) begin
            stateNext    = ST_IDLE;
            midBlockNext = 1'b0;
          end else if (burstMode) begin
            stateNext = ST_W1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      writePass <= 1'b0;
      midBlock  <= 1'b0;
    end else begin
      state     <= stateNext;
      writePass <= writePassNext;
      midBlock  <= midBlockNext;
    end
  end

  assign cmdActive  = (state == ST_W2) || (state == ST_W3) ||
                      (state == ST_WAIT) || (state == ST_W4);
  assign holdReq    = (state != ST_IDLE);
  assign addrStrobe = (state == ST_W1);
  assign rdStrobe   = cmdActive && (memToMem ? !writePass : !dirWrite);
  assign wrStrobe   = cmdActive && (memToMem ?  writePass :  dirWrite);
  assign progEnable = (state == ST_IDLE) && !midBlock;

  assign dpCtl.load     = (state == ST_IDLE) && chanReq && !midBlock;
  assign dpCtl.wordDone = passEnd && (!memToMem || writePass);
  assign dpCtl.capture  = passEnd && memToMem && !writePass;
  assign dpCtl.useDst   = memToMem && writePass;
  assign eot            = dpCtl.wordDone && lastWord;

  // R10: strobes never overlap
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrStrobe, rdStrobe, wrStrobe}));

  // R2: no address cycle starts while the grant is absent and nothing runs
  assert_no_cycle_without_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!holdAck && !(addrStrobe || rdStrobe || wrStrobe)) |=> !addrStrobe);

  // R3: address strobe lasts one clock and is followed by a command
  assert_cmd_after_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |=> (!addrStrobe && (rdStrobe || wrStrobe)));

  // R4: wait state persists while ready is low
  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !ready) |=> (state == ST_WAIT));

  // R9: bus released right after end of transfer
  assert_release_after_eot_R9: assert property (@(posedge clk) disable iff (!rstN)
    eot |=> (!holdReq && progEnable));

  // R1: programming never allowed while bus is requested
  assert_prog_only_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    progEnable |-> !holdReq);

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 8,
  parameter int ADDR_STEP = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       dpCtl,
  input  logic          memToMem,
  input  logic [AW-1:0] srcAddr,
  input  logic [AW-1:0] dstAddr,
  input  logic [CW-1:0] wordCount,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] tmpData,
  output logic          lastWord
);

  localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [AW-1:0] curSrc, curDst;
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc <= '0;
      curDst <= '0;
      remain <= '0;
    end else if (dpCtl.load) begin
      curSrc <= srcAddr;
      curDst <= dstAddr;
      remain <= wordCount;
    end else if (dpCtl.wordDone) begin
      curSrc <= curSrc + STEP;
      if (memToMem) curDst <= curDst + STEP;
      remain <= remain - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              tmpData <= '0;
    else if (dpCtl.capture) tmpData <= memRdata;
  end

  assign busAddr  = dpCtl.useDst ? curDst : curSrc;
  assign lastWord = (remain == '0);

  // R5: temporary register changes only on capture
  assert_tmp_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.capture |=> $stable(tmpData));

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chanReq,
  input  logic          holdAck,
  input  logic          ready,
  input  logic          burstMode,
  input  logic          memToMem,
  input  logic          dirWrite,
  input  logic [AW-1:0] srcAddr,
  input  logic [AW-1:0] dstAddr,
  input  logic [CW-1:0] wordCount,
  input  logic [DW-1:0] memRdata,
  output logic          holdReq,
  output logic          addrStrobe,
  output logic          rdStrobe,
  output logic          wrStrobe,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] tmpData,
  output logic          eot,
  output logic          progEnable
);

  dpCtrl_t dpCtl;
  logic    lastWord;

  dma_seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chanReq    (chanReq),
    .holdAck    (holdAck),
    .ready      (ready),
    .burstMode  (burstMode),
    .memToMem   (memToMem),
    .dirWrite   (dirWrite),
    .lastWord   (lastWord),
    .holdReq    (holdReq),
    .addrStrobe (addrStrobe),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .eot        (eot),
    .progEnable (progEnable),
    .dpCtl      (dpCtl)
  );

  dma_seq_dpath #(.AW(AW), .DW(DW), .CW(CW), .ADDR_STEP(1)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .memToMem  (memToMem),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .wordCount (wordCount),
    .memRdata  (memRdata),
    .busAddr   (busAddr),
    .tmpData   (tmpData),
    .lastWord  (lastWord)
  );

endmodule

// File: tb/test_dma_cycle_seq.sv
module test_dma_cycle_seq;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanReq = 1'b0, ackEnable = 1'b1;
  logic burstMode = 1'b0, memToMem = 1'b0, dirWrite = 1'b0;
  logic [AW-1:0] srcAddr = '0, dstAddr = '0;
  logic [CW-1:0] wordCount = '0;
  logic holdAck, ready;
  logic [DW-1:0] memRdata;
  logic holdReq, addrStrobe, rdStrobe, wrStrobe, eot, progEnable;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] tmpData;

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // bench-side target model
  int cyc = 0;
  int curWaits = 0;
  assign holdAck  = holdReq && ackEnable;
  assign ready    = !(cyc >= 2 && cyc < 2 + curWaits);
  assign memRdata = busAddr[7:0] ^ 8'hA5;

  dma_cycle_seq #(.AW(AW), .DW(DW), .CW(CW)) i_dma_cycle_seq (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .holdAck(holdAck), .ready(ready),
    .burstMode(burstMode), .memToMem(memToMem), .dirWrite(dirWrite),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .wordCount(wordCount), .memRdata(memRdata),
    .holdReq(holdReq), .addrStrobe(addrStrobe), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .busAddr(busAddr), .tmpData(tmpData), .eot(eot), .progEnable(progEnable)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor counters (never cleared; scenarios take deltas)
  int holdCyc = 0, holdFalls = 0, rdCyc = 0, wrCyc = 0, eotCnt = 0, aleCnt = 0;
  logic prevHold = 1'b0;
  logic [AW-1:0] expSrc = '0, expDst = '0, wordSrc = '0;
  bit inWrite = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (addrStrobe) cyc = 0; else cyc = cyc + 1;
      if (holdReq) holdCyc++;
      if (prevHold && !holdReq) holdFalls++;
      prevHold = holdReq;
      if (rdStrobe) rdCyc++;
      if (wrStrobe) wrCyc++;
      if (eot) eotCnt++;
      if (addrStrobe) begin
        aleCnt++;
        if (memToMem && inWrite) begin
          check(busAddr == expDst, "R6", "copy destination address", busAddr, expDst);
          check(tmpData == (wordSrc[7:0] ^ 8'hA5), "R5", "copied data", tmpData,
                wordSrc[7:0] ^ 8'hA5);
          expSrc = expSrc + 1;
          expDst = expDst + 1;
          inWrite = 0;
        end else begin
          check(busAddr == expSrc, "R6", "source address", busAddr, expSrc);
          wordSrc = expSrc;
          if (memToMem) inWrite = 1;
          else expSrc = expSrc + 1;
        end
      end
    end
  end

  // scenario table: {burst, m2m, dirWrite, count[3:0], waits[1:0]}
  localparam int NVEC = 6;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 4'd3, 2'd0},
    {1'b1, 1'b0, 1'b0, 4'd0, 2'd2},
    {1'b0, 1'b0, 1'b1, 4'd2, 2'd1},
    {1'b1, 1'b1, 1'b0, 4'd2, 2'd0},
    {1'b0, 1'b1, 1'b0, 4'd1, 2'd3},
    {1'b1, 1'b1, 1'b1, 4'd0, 2'd1}
  };

  task automatic runScenario(input bit b, input bit m, input bit d, input int cnt,
                             input int w, input logic [AW-1:0] src,
                             input logic [AW-1:0] dst, input bit scramble);
    int h0, f0, r0, w0, e0, a0;
    int n, p, per;
    bit done;
    @(negedge clk);
    h0 = holdCyc; f0 = holdFalls; r0 = rdCyc; w0 = wrCyc; e0 = eotCnt; a0 = aleCnt;
    burstMode = b; memToMem = m; dirWrite = d; wordCount = CW'(cnt);
    srcAddr = src; dstAddr = dst; curWaits = w;
    expSrc = src; expDst = dst; inWrite = 0;
    chanReq = 1'b1;
    done = 0;
    for (int t = 0; t < 2000 && !done; t++) begin
      @(negedge clk);
      if (scramble && aleCnt > a0) begin
        srcAddr = 16'hDEAD;
        dstAddr = 16'hBEEF;
        wordCount = 8'hFF;
      end
      if (eot) begin
        chanReq = 1'b0;
        done = 1;
      end
    end
    if (!done) check(0, "R9", "eot never seen", 0, 1);
    @(negedge clk);
    check(!holdReq, "R9", "holdReq after eot", holdReq, 0);
    check(progEnable, "R9", "progEnable after eot", progEnable, 1);
    @(negedge clk);
    n = cnt + 1; p = m ? 2 : 1; per = 4 + w;
    check(eotCnt - e0 == 1, "R9", "eot pulses", eotCnt - e0, 1);
    check(aleCnt - a0 == n * p, "R6", "address strobes", aleCnt - a0, n * p);
    check(holdCyc - h0 == (b ? 1 + n * p * per : n * (1 + p * per)), "R4",
          "hold cycles", holdCyc - h0, b ? 1 + n * p * per : n * (1 + p * per));
    check(holdFalls - f0 == (b ? 1 : n), b ? "R7" : "R8", "hold releases",
          holdFalls - f0, b ? 1 : n);
    check(rdCyc - r0 == ((m || !d) ? n * (3 + w) : 0), m ? "R5" : "R10", "read cycles",
          rdCyc - r0, (m || !d) ? n * (3 + w) : 0);
    check(wrCyc - w0 == ((m || d) ? n * (3 + w) : 0), m ? "R5" : "R10", "write cycles",
          wrCyc - w0, (m || d) ? n * (3 + w) : 0);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!holdReq && !addrStrobe && !rdStrobe && !wrStrobe && !eot, "R1",
          "outputs quiet after reset", {holdReq, addrStrobe, rdStrobe, wrStrobe, eot}, 0);
    check(progEnable, "R1", "progEnable after reset", progEnable, 1);

    // table walk (R3..R10)
    for (int i = 0; i < NVEC; i++) begin
      runScenario(VEC[i][8], VEC[i][7], VEC[i][6], int'(VEC[i][5:2]), int'(VEC[i][1:0]),
                  16'h1000 + AW'(i) * 16'h0110, 16'h8000 + AW'(i) * 16'h0033, 0);
    end

    // R2: grant withheld, sequencer waits
    ackEnable = 1'b0;
    burstMode = 1'b1; memToMem = 1'b0; dirWrite = 1'b1; wordCount = '0;
    srcAddr = 16'h4242; expSrc = 16'h4242; inWrite = 0; curWaits = 0;
    begin
      int a0;
      a0 = aleCnt;
      chanReq = 1'b1;
      @(negedge clk);
      check(holdReq, "R2", "holdReq one cycle after request", holdReq, 1);
      repeat (6) @(negedge clk);
      check(holdReq, "R2", "holdReq held while waiting", holdReq, 1);
      check(aleCnt == a0, "R2", "no cycle before grant", aleCnt - a0, 0);
      check(!progEnable, "R1", "progEnable while requesting", progEnable, 0);
      ackEnable = 1'b1;
      for (int t = 0; t < 50 && !eot; t++) @(negedge clk);
      chanReq = 1'b0;
      check(eot, "R2", "transfer completes after grant", eot, 1);
      repeat (2) @(negedge clk);
      check(aleCnt - a0 == 1, "R3", "one address strobe", aleCnt - a0, 1);
    end

    // R8: single-mode copy, ports changed mid-block are ignored
    runScenario(1'b0, 1'b1, 1'b0, 2, 1, 16'h2200, 16'h9900, 1);
    // R8: single-mode fly-by with reprogramming mid-block
    runScenario(1'b0, 1'b0, 1'b0, 3, 0, 16'h3300, 16'h0000, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule